// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the timing core of a master on a single open-drain data line shared with one or more slave devices. A higher layer hands it one operation at a time: a bus reset with presence detection, the write of one bit, or the read of one bit. The engine pulls the line low through an enable output and releases it to an external pull-up. It watches the line through a two-flop synchroniser. It times every phase in microseconds, counted from a one-cycle tick strobe supplied by the surrounding clock logic.

A command is accepted on a cycle where `cmd_valid` is high and the engine is idle. `busy` rises on the next edge and stays high until the whole slot or reset window, including recovery, has passed. `done` then pulses for one cycle. The read bit and the presence result are held in output registers until an operation of the same kind replaces them. The engine does not frame bytes, order commands or walk a search tree; that work belongs to the layer above.

The fixed timing is a 480 µs reset low followed by a 480 µs high window, with the presence sample taken 70 µs after release. Bit slots are 70 µs long. A 1 is written with a 6 µs low and a 0 with a 60 µs low. A read drives a 6 µs low and samples 14 µs after the slot starts, inside the window where a slave's data is guaranteed valid.

Top module: `swire_link_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, until a command is accepted, `busy`, `done`, `line_drive_low`, `rd_bit` and `presence` are all 0.
- R2: A reset operation (`cmd_op` = 2'b00) holds `line_drive_low` high for 480 tick periods and keeps `busy` high for 960 tick periods in total. The line is never driven for 960 ticks or more.
- R3: `presence` is set to 1 when the synchronised line is low 70 ticks after a reset releases the line, and to 0 when it is high there. Only reset operations change `presence`.
- R4: A write (`cmd_op` = 2'b01) with `cmd_wbit` = 1 drives the line low for 6 ticks, in a slot where `busy` lasts 70 ticks.
- R5: A write with `cmd_wbit` = 0 drives the line low for 60 ticks, in a slot where `busy` lasts 70 ticks.
- R6: A read (`cmd_op` = 2'b10) drives the line low for 6 ticks, with `busy` lasting 70 ticks. `rd_bit` takes the synchronised line level 14 ticks after the slot starts. Only read operations change `rd_bit`.
- R7: A `cmd_valid` pulse while `busy` is high is ignored. The running operation keeps its low time and its length, and no extra operation follows it.
- R8: `done` is high for exactly one cycle at the end of every operation, on the same edge where `busy` falls.
- R9: `cmd_op` = 2'b11 is not a command. With `cmd_valid` high it leaves `busy` and `line_drive_low` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 00 reset, 01 write bit, 10 read bit, 11 unused |
| cmd_wbit | input | 1 | Bit value for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| line_drive_low | output | 1 | Enable for the open-drain pull-down |
| line_in | input | 1 | Raw level of the shared line |
| rd_bit | output | 1 | Bit captured by the last read |
| presence | output | 1 | Slave presence seen in the last reset |

## Verification
The bench measures every low phase and every busy window in clock cycles. It converts them to ticks, so a low time or slot that is one tick too long or too short shows up directly. A slave model answers resets with a presence pulse and reads with a 0 held for 15 µs. A sample point placed after the data valid window would return 1 instead of 0, and a presence sample that is too early or too late would miss the pulse. Commands are fired into a running slot and an unused op code is offered while idle: an engine that accepted either would produce an extra `done` that has no expected result, or a shortened low time. Reset and read are interleaved so that a result register overwritten by the wrong kind of operation is caught.

// File: rtl/swl_pkg.sv
`timescale 1ns/1ps
// Shared types for the single-wire slot engine.
// Assumes: the op encoding below is the one seen on the cmd_op port.
package swl_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_NONE  = 2'b11
    } swl_op_e;
endpackage

// File: rtl/swl_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for the raw line level.
// Assumes: the idle line is high, so the stages reset to 1.
module swl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the raw level through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/swl_us_timer.sv
`timescale 1ns/1ps
// Microsecond counter for one operation window.
// Assumes: clear and a tick never need to count in the same cycle; clear wins.
module swl_us_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    // Count elapsed ticks while an operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (clear)        cnt <= '0;
        else if (run && tick)  cnt <= cnt + 1'b1;
    end

    // R2: the window advances by exactly one per counted tick
    a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !clear) |=> (cnt == $past(cnt) + 1'b1));
    // R7: the count holds while no tick arrives
    a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/swl_slot_seq.sv
`timescale 1ns/1ps
// Operation sequencer: accepts a command, drives the low phase, samples
// the line and closes the window.
// Assumes: cnt comes from swl_us_timer, cleared on accept and run while busy;
// line_s is already synchronised.
module swl_slot_seq
    import swl_pkg::*;
#(
    parameter int CW          = 10,
    parameter int RST_LOW_US  = 480,
    parameter int RST_HIGH_US = 480,
    parameter int PRES_AT_US  = 70,
    parameter int SLOT_US     = 70,
    parameter int W1_LOW_US   = 6,
    parameter int W0_LOW_US   = 60,
    parameter int RD_LOW_US   = 6,
    parameter int RD_SMP_US   = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_us,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_wbit,
    input  logic          line_s,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clear,
    output logic          busy,
    output logic          done,
    output logic          drive_low,
    output logic          rd_bit,
    output logic          presence
);
    localparam int RST_END_US = RST_LOW_US + RST_HIGH_US;
    localparam int RST_SMP_US = RST_LOW_US + PRES_AT_US;
    localparam int RST_CAP_US = 960;
    localparam int RD_VALID_US = 15;

    swl_op_e       op_q;
    logic          wbit_q;
    logic          accept;
    logic          step;
    logic [CW-1:0] nxt;
    logic [CW-1:0] low_len;
    logic [CW-1:0] end_at;
    logic [CW-1:0] smp_at;
    logic          smp_en;
    logic          smp_hit;

    // Take a command only when idle and the op code is defined.
    assign accept    = cmd_valid && !busy && (swl_op_e'(cmd_op) != OP_NONE);
    assign cnt_clear = accept;
    assign step      = busy && tick_us;
    assign nxt       = cnt + 1'b1;
    assign smp_hit   = step && smp_en && (nxt == smp_at);

    // Select the phase lengths of the running operation.
    always_comb begin
        low_len = CW'(RD_LOW_US);
        end_at  = CW'(SLOT_US);
        smp_at  = CW'(RD_SMP_US);
        smp_en  = 1'b0;
        case (op_q)
            OP_RESET: begin
                low_len = CW'(RST_LOW_US);
                end_at  = CW'(RST_END_US);
                smp_at  = CW'(RST_SMP_US);
                smp_en  = 1'b1;
            end
            OP_WRITE: low_len = wbit_q ? CW'(W1_LOW_US) : CW'(W0_LOW_US);
            OP_READ:  smp_en  = 1'b1;
            default:  smp_en  = 1'b0;
        endcase
    end

    // Run the accept / release / finish sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            drive_low <= 1'b0;
            op_q      <= OP_RESET;
            wbit_q    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy      <= 1'b1;
                drive_low <= 1'b1;
                op_q      <= swl_op_e'(cmd_op);
                wbit_q    <= cmd_wbit;
            end else if (step) begin
                if (nxt == low_len) drive_low <= 1'b0;
                if (nxt == end_at) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Capture the line into the result of the matching operation kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bit   <= 1'b0;
            presence <= 1'b0;
        end else if (smp_hit) begin
            if (op_q == OP_RESET) presence <= !line_s;
            else                  rd_bit   <= line_s;
        end
    end

    // R1: the line is released whenever no operation runs
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drive_low);
    // R2: the low phase ends before its programmed length, and a reset low stays under the cap
    a_r2_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> (cnt < low_len) && (cnt < CW'(RST_CAP_US)));
    // R6: a read sample lies inside the data valid window
    a_r6_sample_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_hit && op_q == OP_READ) |-> (nxt < CW'(RD_VALID_US)));
    // R7: the running operation is frozen while busy
    a_r7_op_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(op_q) && $stable(wbit_q)));
    // R8: every fall of busy comes with done
    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R8: done never lasts two cycles
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: an undefined op code starts nothing
    a_r9_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op == 2'b11) |=> !busy);
endmodule

// File: rtl/swire_link_master.sv
`timescale 1ns/1ps
// Single-wire bus master slot engine: reset/presence, write bit, read bit.
// Assumes: tick_us is a one-cycle strobe once per microsecond; line_in is
// the raw level of an open-drain line with an external pull-up.
module swire_link_master #(
    parameter int SYNC_STAGES = 2,
    parameter int RST_LOW_US  = 480,
    parameter int RST_HIGH_US = 480,
    parameter int PRES_AT_US  = 70,
    parameter int SLOT_US     = 70,
    parameter int W1_LOW_US   = 6,
    parameter int W0_LOW_US   = 60,
    parameter int RD_LOW_US   = 6,
    parameter int RD_SMP_US   = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_wbit,
    output logic       busy,
    output logic       done,
    output logic       line_drive_low,
    input  logic       line_in,
    output logic       rd_bit,
    output logic       presence
);
    localparam int CW = $clog2(RST_LOW_US + RST_HIGH_US + 1);

    logic          line_s;
    logic          cnt_clear;
    logic [CW-1:0] cnt;

    swl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    swl_us_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .run   (busy),
        .tick  (tick_us),
        .cnt   (cnt)
    );

    swl_slot_seq #(
        .CW          (CW),
        .RST_LOW_US  (RST_LOW_US),
        .RST_HIGH_US (RST_HIGH_US),
        .PRES_AT_US  (PRES_AT_US),
        .SLOT_US     (SLOT_US),
        .W1_LOW_US   (W1_LOW_US),
        .W0_LOW_US   (W0_LOW_US),
        .RD_LOW_US   (RD_LOW_US),
        .RD_SMP_US   (RD_SMP_US)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_us   (tick_us),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wbit  (cmd_wbit),
        .line_s    (line_s),
        .cnt       (cnt),
        .cnt_clear (cnt_clear),
        .busy      (busy),
        .done      (done),
        .drive_low (line_drive_low),
        .rd_bit    (rd_bit),
        .presence  (presence)
    );
endmodule

// File: tb/swire_link_master_test.sv
`timescale 1ns/1ps
// Scoreboard bench: run_op pushes the expected timing and results, the
// monitor measures each operation in cycles and compares on done.
module swire_link_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div = 2'd0;
    logic       tick_us;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_wbit = 1'b0;
    logic       busy, done, line_drive_low, line_in, rd_bit, presence;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Tick strobe every 4 cycles, so one "microsecond" is 4 clocks here.
    always @(posedge clk) div <= div + 2'd1;
    assign tick_us = &div;

    swire_link_master uut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wbit(cmd_wbit),
        .busy(busy), .done(done), .line_drive_low(line_drive_low),
        .line_in(line_in), .rd_bit(rd_bit), .presence(presence)
    );

    // Slave model: presence after a long low, a 0 held on a read slot.
    bit   slave_present = 1'b1;
    bit   slave_rd0 = 1'b0;
    logic slave_low = 1'b0;
    logic drv_q = 1'b0;
    int   low_run = 0;
    int   hold = 0;
    int   wait_p = 0;

    assign line_in = !(line_drive_low || slave_low);

    always @(posedge clk) begin
        drv_q <= line_drive_low;
        low_run <= line_drive_low ? low_run + 1 : 0;
        if (hold > 0) begin
            hold <= hold - 1;
            if (hold == 1) slave_low <= 1'b0;
        end
        if (wait_p > 0) begin
            wait_p <= wait_p - 1;
            if (wait_p == 1) begin
                slave_low <= 1'b1;
                hold <= 400;
            end
        end
        if (line_drive_low && !drv_q && slave_rd0) begin
            slave_low <= 1'b1;
            hold <= 60;
        end
        if (!line_drive_low && drv_q && low_run >= 1000 && slave_present)
            wait_p <= 80;
    end

    typedef struct {
        string tag;
        int    low_us;
        int    total_us;
        bit    pres;
        bit    rd;
    } exp_t;
    exp_t exp_q[$];

    bit m_pres = 1'b0;
    bit m_rd   = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, act, expv);
        end
    endtask

    // Monitor: measure low and busy windows, compare on every done.
    int busy_cyc = 0;
    int drv_cyc  = 0;
    bit done_q   = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cyc++;
            if (line_drive_low) drv_cyc++;
            if (done) begin
                chk(!done_q, "R8 done longer than one cycle", 1, 0);
                chk(!busy, "R8 busy still high at done", int'(busy), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 operation with no accepted command", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk((drv_cyc + 3) / 4 == e.low_us, {e.tag, " low time (ticks)"},
                        (drv_cyc + 3) / 4, e.low_us);
                    chk((busy_cyc + 3) / 4 == e.total_us, {e.tag, " busy window (ticks)"},
                        (busy_cyc + 3) / 4, e.total_us);
                    chk(presence == e.pres, {e.tag, " presence (R3)"}, int'(presence), int'(e.pres));
                    chk(rd_bit == e.rd, {e.tag, " rd_bit (R6)"}, int'(rd_bit), int'(e.rd));
                end
                busy_cyc = 0;
                drv_cyc  = 0;
            end
            done_q = done;
        end
    end

    // Driver: push the expected item and issue one command.
    task automatic run_op(input logic [1:0] op, input logic bitv, input string tag);
        exp_t e;
        e.tag = tag;
        if (op == 2'b00) begin
            e.low_us = 480; e.total_us = 960;
            m_pres = slave_present;
        end else if (op == 2'b01) begin
            e.low_us = bitv ? 6 : 60; e.total_us = 70;
        end else begin
            e.low_us = 6; e.total_us = 70;
            m_rd = bitv;
        end
        e.pres = m_pres;
        e.rd   = m_rd;
        exp_q.push_back(e);
        slave_rd0 = (op == 2'b10) && !bitv;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wbit = (op == 2'b01) ? bitv : 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        slave_rd0 = 1'b0;
    endtask

    initial begin
        // R1: state held in reset and right after it
        repeat (6) @(negedge clk);
        chk(!busy && !done && !line_drive_low, "R1 control outputs in reset",
            int'({busy, done, line_drive_low}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !line_drive_low, "R1 idle after reset", int'({busy, line_drive_low}), 0);
        chk(!rd_bit && !presence, "R1 results after reset", int'({rd_bit, presence}), 0);

        // R2, R3: reset with and without a responding slave
        slave_present = 1'b1;
        run_op(2'b00, 1'b0, "R2 reset with slave");
        slave_present = 1'b0;
        run_op(2'b00, 1'b0, "R3 reset without slave");
        slave_present = 1'b1;

        // R4, R5: write slots
        run_op(2'b01, 1'b1, "R4 write 1");
        run_op(2'b01, 1'b0, "R5 write 0");
        run_op(2'b01, 1'b1, "R4 write 1 after 0");

        // R6: reads of both values, back to back
        run_op(2'b10, 1'b0, "R6 read 0");
        run_op(2'b10, 1'b1, "R6 read 1");
        run_op(2'b10, 1'b0, "R6 read 0 again");

        // R3/R6: a reset leaves rd_bit at 0, presence comes back to 1
        run_op(2'b00, 1'b0, "R3 reset keeps rd_bit");
        // R6: a write leaves rd_bit and presence alone
        run_op(2'b01, 1'b0, "R6 write keeps results");

        // R7: commands fired into a running write-1 slot are ignored
        begin
            exp_t e;
            e.tag = "R7 write 1 with stray commands";
            e.low_us = 6; e.total_us = 70; e.pres = m_pres; e.rd = m_rd;
            exp_q.push_back(e);
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'b01; cmd_wbit = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (10) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'b01; cmd_wbit = 1'b0;
            @(negedge clk);
            cmd_op = 2'b00;
            @(negedge clk);
            cmd_valid = 1'b0;
            while (busy) @(negedge clk);
            repeat (20) @(negedge clk);
            chk(!busy, "R7 no follow-on operation", int'(busy), 0);
        end

        // R9: undefined op code while idle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(!busy && !line_drive_low, "R9 op 11 started nothing",
            int'({busy, line_drive_low}), 0);

        chk(exp_q.size() == 0, "R8 every operation produced done", exp_q.size(), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule